// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block is the digital sequencer that sits in front of a successive-approximation converter. It runs two independent conversion contexts. The regular context works through a programmable list of channels in the background. The injected context has a short list of its own and takes priority over the regular one. Each context starts either from its own software start pulse or from one of several hardware trigger lines, and the choice is made per context.

Each conversion is a request/done exchange with the converter. The block presents a channel number and holds a request. The converter answers with a one-cycle done pulse and a 12-bit raw result. The block reduces that result to the selected resolution, places it right- or left-aligned in a 32-bit word and compares it with a low/high window. It then raises one-cycle end-of-conversion, end-of-sequence and out-of-window flags. Regular results land in a single data word. Injected results land in one word per rank of the injected list.

An injected trigger never aborts a regular conversion in flight. The regular conversion finishes and its result is kept. The injected list then runs, and the regular list continues from the rank it would have converted next.

Top module: `adc_sequencer`

## Requirements
- R1: While and after reset, `convReq`, `regData`, every word of `injData` and all five flags are 0.
- R2: `convReq` stays high with `convCh` unchanged until a cycle in which `convDone` is high. In the cycle after that, `convReq` is low.
- R3: The trigger select value 0 picks the context's software start pulse, and value k picks `hwTrig[k-1]`. Pulses on unselected sources are ignored. A selected pulse that arrives while the same context still has work pending is ignored.
- R4: In single mode (`cfgRegMode`=0), one trigger converts one regular rank and raises end-of-sequence with it.
- R5: In scan mode (`cfgRegMode`=1), one trigger converts ranks 0 to `cfgRegLen` in order, once. End-of-sequence comes only with the last rank.
- R6: In continuous mode (`cfgRegMode`=2), the list restarts at rank 0 after its last rank without a new trigger. Switching the mode to scan lets the current pass end and then stops.
- R7: In discontinuous mode (`cfgRegMode`=3), each trigger converts the next `cfgDiscLen`+1 ranks and then waits. A group that reaches the last rank stops there, raises end-of-sequence, and the next trigger starts again at rank 0.
- R8: A pending injected list is always started before the regular list. An injected trigger during a regular conversion lets that conversion finish. The regular list later resumes at the following rank.
- R9: Injected rank r is written only to `injData[32r+31:32r]`. `regData` changes only on a regular end-of-conversion.
- R10: `cfgRes` selects 12, 10, 8 or 6 bits for the values 0, 1, 2 or 3. The low 2·`cfgRes` bits of the raw result are dropped.
- R11: With `cfgLeftAlign`=0, the reduced value sits at bit 0. With `cfgLeftAlign`=1, its MSB sits at bit 31 and all lower bits are 0.
- R12: `wdFlag` pulses together with the end-of-conversion flag when the reduced value is strictly above `cfgWdHigh` or strictly below `cfgWdLow`. Equal values are not flagged.
- R13: End-of-conversion and end-of-sequence flags are one-cycle pulses, raised in the cycle after `convDone`. Regular and injected flags are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgRes | input | 2 | Resolution select (0:12, 1:10, 2:8, 3:6 bits) |
| cfgLeftAlign | input | 1 | 1 = left-align result at bit 31 |
| cfgRegMode | input | 2 | Regular mode: 0 single, 1 scan, 2 continuous, 3 discontinuous |
| cfgRegLen | input | 3 | Regular list length minus one |
| cfgDiscLen | input | 3 | Discontinuous group size minus one |
| cfgRegSeq | input | 40 | Regular channel list, rank r at bits [5r+4:5r] |
| cfgInjLen | input | 2 | Injected list length minus one |
| cfgInjSeq | input | 20 | Injected channel list, rank r at bits [5r+4:5r] |
| cfgRegTrigSel | input | 3 | Regular trigger source select |
| cfgInjTrigSel | input | 3 | Injected trigger source select |
| cfgWdHigh | input | 12 | Upper window threshold at selected resolution |
| cfgWdLow | input | 12 | Lower window threshold at selected resolution |
| swRegStart | input | 1 | Software start pulse, regular context |
| swInjStart | input | 1 | Software start pulse, injected context |
| hwTrig | input | 4 | Hardware trigger pulses |
| convReq | output | 1 | Conversion request to the converter |
| convCh | output | 5 | Channel to convert |
| convDone | input | 1 | Converter done pulse |
| convData | input | 12 | Raw converter result |
| regData | output | 32 | Last regular result, aligned |
| injData | output | 128 | Injected results, one 32-bit word per rank |
| eocReg | output | 1 | Regular end-of-conversion pulse |
| eocInj | output | 1 | Injected end-of-conversion pulse |
| eosReg | output | 1 | Regular end-of-sequence pulse |
| eosInj | output | 1 | Injected end-of-sequence pulse |
| wdFlag | output | 1 | Result outside the watchdog window |

## Verification
The sharpest collision is between an injected trigger and the completion of a regular conversion in the same clock cycle. The bench drives `swInjStart` in exactly the cycle in which the converter model answers the second regular rank. It then requires the converted channel order to be regular rank 0, regular rank 1, the whole injected list, and then the remaining regular ranks. It also requires `regData` to keep the rank-1 result throughout the injected flags. A second overlap, the watchdog flag landing together with end-of-sequence in single mode, is judged by counting flags at the ports.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  // Widest rank index carried between control and datapath (up to 8 ranks).
  localparam int STB_RANK_W = 3;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_SCAN   = 2'd1,
    MODE_CONT   = 2'd2,
    MODE_DISC   = 2'd3
  } regMode_e;

  // Strobes from control to datapath, valid in the convDone cycle.
  typedef struct packed {
    logic                  wr;
    logic                  isInj;
    logic                  last;
    logic [STB_RANK_W-1:0] rank;
  } convStrobe_t;

endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int CH_W      = 5,
  parameter int REG_RANKS = 8,
  parameter int INJ_RANKS = 4,
  parameter int NUM_HW    = 4,
  localparam int REG_LEN_W = $clog2(REG_RANKS),
  localparam int INJ_LEN_W = $clog2(INJ_RANKS),
  localparam int SEL_W     = $clog2(NUM_HW + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  regMode_e                    cfgMode,
  input  logic [REG_LEN_W-1:0]        cfgRegLen,
  input  logic [REG_LEN_W-1:0]        cfgDiscLen,
  input  logic [REG_RANKS*CH_W-1:0]   cfgRegSeq,
  input  logic [INJ_LEN_W-1:0]        cfgInjLen,
  input  logic [INJ_RANKS*CH_W-1:0]   cfgInjSeq,
  input  logic [SEL_W-1:0]            cfgRegSel,
  input  logic [SEL_W-1:0]            cfgInjSel,
  input  logic                        swReg,
  input  logic                        swInj,
  input  logic [NUM_HW-1:0]           hwTrig,
  output logic                        convReq,
  output logic [CH_W-1:0]             convCh,
  input  logic                        convDone,
  output convStrobe_t                 stb
);

  typedef enum logic {ST_IDLE, ST_CONV} state_e;

  state_e               state;
  logic                 curInj;
  logic                 regActive, injActive;
  logic [REG_LEN_W-1:0] regIdx, grpCnt;
  logic [INJ_LEN_W-1:0] injIdx;

  logic                 regActN, injActN;
  logic [REG_LEN_W-1:0] regIdxN, grpN;
  logic [INJ_LEN_W-1:0] injIdxN;
  logic                 regLast, injLast;
  logic                 regTrigHit, injTrigHit;
  logic                 doneNow;

  logic [CH_W-1:0] regCh [REG_RANKS];
  logic [CH_W-1:0] injCh [INJ_RANKS];

  for (genvar r = 0; r < REG_RANKS; r++) begin : g_regCh
    assign regCh[r] = cfgRegSeq[r*CH_W +: CH_W];
  end
  for (genvar r = 0; r < INJ_RANKS; r++) begin : g_injCh
    assign injCh[r] = cfgInjSeq[r*CH_W +: CH_W];
  end

  // Trigger source selection: 0 = software, k = hwTrig[k-1]
  always_comb begin
    regTrigHit = (cfgRegSel == '0) ? swReg : 1'b0;
    injTrigHit = (cfgInjSel == '0) ? swInj : 1'b0;
    for (int k = 0; k < NUM_HW; k++) begin
      if (cfgRegSel == SEL_W'(k + 1)) regTrigHit = hwTrig[k];
      if (cfgInjSel == SEL_W'(k + 1)) injTrigHit = hwTrig[k];
    end
  end

  assign doneNow = (state == ST_CONV) && convDone;

  // Regular context progression
  always_comb begin
    regActN = regActive;
    regIdxN = regIdx;
    grpN    = grpCnt;
    regLast = 1'b0;
    if (doneNow && !curInj) begin
      if (cfgMode == MODE_SINGLE || regIdx == cfgRegLen) begin
        regIdxN = '0;
        grpN    = '0;
        regLast = 1'b1;
        regActN = (cfgMode == MODE_CONT);
      end else begin
        regIdxN = regIdx + 1'b1;
        if (cfgMode == MODE_DISC) begin
          if (grpCnt == cfgDiscLen) begin
            grpN    = '0;
            regActN = 1'b0;
          end else begin
            grpN = grpCnt + 1'b1;
          end
        end
      end
    end
    if (regTrigHit && !regActive) regActN = 1'b1;
  end

  // Injected context progression
  always_comb begin
    injActN = injActive;
    injIdxN = injIdx;
    injLast = 1'b0;
    if (doneNow && curInj) begin
      if (injIdx == cfgInjLen) begin
        injIdxN = '0;
        injActN = 1'b0;
        injLast = 1'b1;
      end else begin
        injIdxN = injIdx + 1'b1;
      end
    end
    if (injTrigHit && !injActive) injActN = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      curInj    <= 1'b0;
      convCh    <= '0;
      regActive <= 1'b0;
      injActive <= 1'b0;
      regIdx    <= '0;
      grpCnt    <= '0;
      injIdx    <= '0;
    end else begin
      regActive <= regActN;
      injActive <= injActN;
      regIdx    <= regIdxN;
      grpCnt    <= grpN;
      injIdx    <= injIdxN;
      unique case (state)
        ST_IDLE: begin
          if (injActive) begin
            state  <= ST_CONV;
            curInj <= 1'b1;
            convCh <= injCh[injIdx];
          end else if (regActive) begin
            state  <= ST_CONV;
            curInj <= 1'b0;
            convCh <= regCh[regIdx];
          end
        end
        ST_CONV: if (convDone) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign convReq   = (state == ST_CONV);
  assign stb.wr    = doneNow;
  assign stb.isInj = curInj;
  assign stb.last  = curInj ? injLast : regLast;
  assign stb.rank  = curInj ? STB_RANK_W'(injIdx) : STB_RANK_W'(regIdx);

  // R2: request and channel held until the converter answers
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && !convDone) |=> (convReq && $stable(convCh)));

  // R2: request drops for a cycle after done
  a_r2_req_gap: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && convDone) |=> !convReq);

  // R8: pending injected work is started ahead of regular work
  a_r8_inj_first: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && injActive) |=> (convReq && curInj));

endmodule

// File: rtl/adcseq_dpath.sv
module adcseq_dpath
  import adcseq_pkg::*;
#(
  parameter int RAW_W     = 12,
  parameter int DATA_W    = 32,
  parameter int INJ_RANKS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [1:0]                  cfgRes,
  input  logic                        cfgLeft,
  input  logic [RAW_W-1:0]            cfgWdHigh,
  input  logic [RAW_W-1:0]            cfgWdLow,
  input  logic [RAW_W-1:0]            convData,
  input  convStrobe_t                 stb,
  output logic [DATA_W-1:0]           regData,
  output logic [INJ_RANKS*DATA_W-1:0] injData,
  output logic                        eocReg,
  output logic                        eocInj,
  output logic                        eosReg,
  output logic                        eosInj,
  output logic                        wdFlag
);

  localparam int LEFT_SH = DATA_W - RAW_W;

  logic [2:0]        dropBits;
  logic [RAW_W-1:0]  scaled, kept;
  logic [DATA_W-1:0] word;
  logic              wdHit;

  always_comb begin
    dropBits = {cfgRes, 1'b0};
    scaled   = convData >> dropBits;
    kept     = convData & ({RAW_W{1'b1}} << dropBits);
    word     = cfgLeft ? (DATA_W'(kept) << LEFT_SH) : DATA_W'(scaled);
    wdHit    = (scaled > cfgWdHigh) || (scaled < cfgWdLow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regData <= '0;
      eocReg  <= 1'b0;
      eocInj  <= 1'b0;
      eosReg  <= 1'b0;
      eosInj  <= 1'b0;
      wdFlag  <= 1'b0;
    end else begin
      if (stb.wr && !stb.isInj) regData <= word;
      eocReg <= stb.wr && !stb.isInj;
      eocInj <= stb.wr && stb.isInj;
      eosReg <= stb.wr && !stb.isInj && stb.last;
      eosInj <= stb.wr && stb.isInj && stb.last;
      wdFlag <= stb.wr && wdHit;
    end
  end

  logic [DATA_W-1:0] injQ [INJ_RANKS];

  for (genvar r = 0; r < INJ_RANKS; r++) begin : g_injReg
    always_ff @(posedge clk) begin
      if (!rstN) injQ[r] <= '0;
      else if (stb.wr && stb.isInj && stb.rank == STB_RANK_W'(r)) injQ[r] <= word;
    end
    assign injData[r*DATA_W +: DATA_W] = injQ[r];
  end

  // R13: regular and injected completion never flagged together
  a_r13_eoc_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eocReg, eocInj}));

  // R13: end-of-sequence only with its end-of-conversion
  a_r13_eos_with_eoc: assert property (@(posedge clk) disable iff (!rstN)
    (eosReg |-> eocReg) and (eosInj |-> eocInj));

  // R9: regular word untouched unless a regular result is written
  a_r9_reg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wr && !stb.isInj) |=> $stable(regData));

  // R12: window flag only alongside a completed conversion
  a_r12_wd_with_eoc: assert property (@(posedge clk) disable iff (!rstN)
    wdFlag |-> (eocReg || eocInj));

endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
  import adcseq_pkg::*;
#(
  parameter int CH_W      = 5,
  parameter int RAW_W     = 12,
  parameter int DATA_W    = 32,
  parameter int REG_RANKS = 8,
  parameter int INJ_RANKS = 4,
  parameter int NUM_HW    = 4,
  localparam int REG_LEN_W = $clog2(REG_RANKS),
  localparam int INJ_LEN_W = $clog2(INJ_RANKS),
  localparam int SEL_W     = $clog2(NUM_HW + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [1:0]                  cfgRes,
  input  logic                        cfgLeftAlign,
  input  logic [1:0]                  cfgRegMode,
  input  logic [REG_LEN_W-1:0]        cfgRegLen,
  input  logic [REG_LEN_W-1:0]        cfgDiscLen,
  input  logic [REG_RANKS*CH_W-1:0]   cfgRegSeq,
  input  logic [INJ_LEN_W-1:0]        cfgInjLen,
  input  logic [INJ_RANKS*CH_W-1:0]   cfgInjSeq,
  input  logic [SEL_W-1:0]            cfgRegTrigSel,
  input  logic [SEL_W-1:0]            cfgInjTrigSel,
  input  logic [RAW_W-1:0]            cfgWdHigh,
  input  logic [RAW_W-1:0]            cfgWdLow,
  input  logic                        swRegStart,
  input  logic                        swInjStart,
  input  logic [NUM_HW-1:0]           hwTrig,
  output logic                        convReq,
  output logic [CH_W-1:0]             convCh,
  input  logic                        convDone,
  input  logic [RAW_W-1:0]            convData,
  output logic [DATA_W-1:0]           regData,
  output logic [INJ_RANKS*DATA_W-1:0] injData,
  output logic                        eocReg,
  output logic                        eocInj,
  output logic                        eosReg,
  output logic                        eosInj,
  output logic                        wdFlag
);

  convStrobe_t stb;

  adcseq_ctrl #(
    .CH_W(CH_W), .REG_RANKS(REG_RANKS), .INJ_RANKS(INJ_RANKS), .NUM_HW(NUM_HW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgMode(regMode_e'(cfgRegMode)),
    .cfgRegLen(cfgRegLen), .cfgDiscLen(cfgDiscLen), .cfgRegSeq(cfgRegSeq),
    .cfgInjLen(cfgInjLen), .cfgInjSeq(cfgInjSeq),
    .cfgRegSel(cfgRegTrigSel), .cfgInjSel(cfgInjTrigSel),
    .swReg(swRegStart), .swInj(swInjStart), .hwTrig(hwTrig),
    .convReq(convReq), .convCh(convCh), .convDone(convDone),
    .stb(stb)
  );

  adcseq_dpath #(
    .RAW_W(RAW_W), .DATA_W(DATA_W), .INJ_RANKS(INJ_RANKS)
  ) u_dpath (
    .clk(clk), .rstN(rstN),
    .cfgRes(cfgRes), .cfgLeft(cfgLeftAlign),
    .cfgWdHigh(cfgWdHigh), .cfgWdLow(cfgWdLow),
    .convData(convData), .stb(stb),
    .regData(regData), .injData(injData),
    .eocReg(eocReg), .eocInj(eocInj), .eosReg(eosReg), .eosInj(eosInj),
    .wdFlag(wdFlag)
  );

endmodule

// File: tb/sim_adc_sequencer.sv
`timescale 1ns/1ps
module sim_adc_sequencer;

  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   cfgRes = 2'd0;
  logic         cfgLeftAlign = 1'b0;
  logic [1:0]   cfgRegMode = 2'd0;
  logic [2:0]   cfgRegLen = 3'd0;
  logic [2:0]   cfgDiscLen = 3'd0;
  logic [39:0]  cfgRegSeq = '0;
  logic [1:0]   cfgInjLen = 2'd0;
  logic [19:0]  cfgInjSeq = '0;
  logic [2:0]   cfgRegTrigSel = 3'd0;
  logic [2:0]   cfgInjTrigSel = 3'd0;
  logic [11:0]  cfgWdHigh = 12'hFFF;
  logic [11:0]  cfgWdLow = 12'h000;
  logic         swRegStart = 1'b0;
  logic         swInjStart = 1'b0;
  logic [3:0]   hwTrig = 4'd0;
  logic         convReq;
  logic [4:0]   convCh;
  logic         convDone;
  logic [11:0]  convData;
  logic [31:0]  regData;
  logic [127:0] injData;
  logic         eocReg, eocInj, eosReg, eosInj, wdFlag;

  adc_sequencer u0 (.*);

  always #5 clk = ~clk;

  function automatic int model(input int ch);
    return (ch * 197 + 51) % 4096;
  endfunction

  function automatic longint expWord(input int raw, input int res, input bit left);
    int drop;
    drop = 2 * res;
    if (left) return longint'((raw >> drop) << drop) << 20;
    return longint'(raw >> drop);
  endfunction

  // Converter model
  int mdlCnt = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      convDone <= 1'b0;
      convData <= '0;
      mdlCnt   <= 0;
    end else begin
      convDone <= 1'b0;
      if (convReq && !convDone) begin
        if (mdlCnt == LAT - 1) begin
          convDone <= 1'b1;
          convData <= 12'(model(int'(convCh)));
          mdlCnt   <= 0;
        end else begin
          mdlCnt <= mdlCnt + 1;
        end
      end
    end
  end

  // Port monitor
  int chLog [64];
  int nLog, nEocReg, nEocInj, nEosReg, nEosInj, nWd, wdOrphan, r2Err, nRegAtInj;
  longint lastReg;
  longint regAtInj [8];
  logic prevReq = 1'b0, prevDone = 1'b0;
  logic [4:0] prevCh = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (convReq && convDone && nLog < 64) begin
        chLog[nLog] = int'(convCh);
        nLog++;
      end
      if (convReq && prevReq && !prevDone && convCh != prevCh) r2Err++;
      if (prevDone && convReq) r2Err++;
      if (eocReg) begin nEocReg++; lastReg = longint'(regData); end
      if (eocInj) begin
        nEocInj++;
        if (nRegAtInj < 8) begin regAtInj[nRegAtInj] = longint'(regData); nRegAtInj++; end
      end
      if (eosReg) nEosReg++;
      if (eosInj) nEosInj++;
      if (wdFlag) nWd++;
      if (wdFlag && !(eocReg || eocInj)) wdOrphan++;
    end
    prevReq  = convReq;
    prevDone = convDone;
    prevCh   = convCh;
  end

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    nLog = 0; nEocReg = 0; nEocInj = 0; nEosReg = 0; nEosInj = 0;
    nWd = 0; wdOrphan = 0; nRegAtInj = 0; lastReg = 0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitQuiet();
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (convReq) q = 0; else q++;
    end
  endtask

  task automatic pulseSwReg();
    @(negedge clk); swRegStart = 1'b1;
    @(negedge clk); swRegStart = 1'b0;
  endtask

  task automatic setReg(input int rank, input int ch);
    cfgRegSeq[rank*5 +: 5] = 5'(ch);
  endtask

  task automatic setInj(input int rank, input int ch);
    cfgInjSeq[rank*5 +: 5] = 5'(ch);
  endtask

  task automatic t_reset();
    doReset();
    @(negedge clk);
    check(convReq == 1'b0, "R1 convReq", convReq, 0);
    check(regData == 0 && injData == 0, "R1 data", regData, 0);
    check({eocReg, eocInj, eosReg, eosInj, wdFlag} == 0, "R1 flags",
          {eocReg, eocInj, eosReg, eosInj, wdFlag}, 0);
  endtask

  task automatic t_trigsel();
    doReset();
    cfgRegMode = 2'd0; setReg(0, 3); cfgRegLen = 3'd2; cfgRegTrigSel = 3'd2;
    pulseSwReg();
    repeat (15) @(negedge clk);
    check(nLog == 0, "R3 sw ignored when hw selected", nLog, 0);
    @(negedge clk); hwTrig = 4'b0001;
    @(negedge clk); hwTrig = 4'b0000;
    repeat (15) @(negedge clk);
    check(nLog == 0, "R3 unselected hw ignored", nLog, 0);
    @(negedge clk); hwTrig = 4'b0010;
    @(negedge clk); hwTrig = 4'b0000;
    waitQuiet();
    check(nLog == 1 && chLog[0] == 3, "R3 selected hw line", nLog, 1);
    check(nEosReg == 1, "R4 single eos", nEosReg, 1);
    check(lastReg == expWord(model(3), 0, 0), "R4 single data", lastReg, expWord(model(3), 0, 0));
    cfgRegTrigSel = 3'd0;
  endtask

  task automatic t_scan();
    doReset();
    cfgRegMode = 2'd1; cfgRegLen = 3'd2;
    setReg(0, 3); setReg(1, 5); setReg(2, 7);
    pulseSwReg();
    while (nLog < 1) @(negedge clk);
    pulseSwReg();   // trigger during a pending sequence
    waitQuiet();
    check(nLog == 3, "R3 busy trigger ignored", nLog, 3);
    check(chLog[0] == 3 && chLog[1] == 5 && chLog[2] == 7, "R5 scan order", chLog[2], 7);
    check(nEocReg == 3, "R13 eoc count", nEocReg, 3);
    check(nEosReg == 1, "R5 eos once", nEosReg, 1);
    check(r2Err == 0, "R2 handshake", r2Err, 0);
  endtask

  task automatic t_cont();
    doReset();
    cfgRegMode = 2'd2; cfgRegLen = 3'd2;
    setReg(0, 3); setReg(1, 5); setReg(2, 7);
    pulseSwReg();
    while (nLog < 7) @(negedge clk);
    cfgRegMode = 2'd1;
    waitQuiet();
    check(chLog[3] == 3 && chLog[4] == 5 && chLog[6] == 3, "R6 restart at rank0", chLog[6], 3);
    check(nLog % 3 == 0, "R6 stops at list end", nLog % 3, 0);
    check(nEosReg == nLog / 3, "R6 eos per pass", nEosReg, nLog / 3);
  endtask

  task automatic t_disc();
    int exp [11] = '{1, 2, 3, 4, 5, 1, 2, 3, 4, 5, 0};
    int cnt [6] = '{2, 4, 5, 7, 9, 10};
    doReset();
    cfgRegMode = 2'd3; cfgRegLen = 3'd4; cfgDiscLen = 3'd1;
    for (int i = 0; i < 5; i++) setReg(i, i + 1);
    for (int t = 0; t < 6; t++) begin
      pulseSwReg();
      waitQuiet();
      check(nLog == cnt[t], "R7 group size", nLog, cnt[t]);
    end
    for (int i = 0; i < 10; i++)
      check(chLog[i] == exp[i], "R7 group order", chLog[i], exp[i]);
    check(nEosReg == 2, "R7 eos on wrap", nEosReg, 2);
  endtask

  task automatic t_preempt();
    int exp [7] = '{1, 2, 16, 17, 3, 4, 5};
    doReset();
    cfgRegMode = 2'd1; cfgRegLen = 3'd4;
    for (int i = 0; i < 5; i++) setReg(i, i + 1);
    cfgInjLen = 2'd1; setInj(0, 16); setInj(1, 17);
    pulseSwReg();
    do @(negedge clk); while (!(convDone && convCh == 5'd2));
    swInjStart = 1'b1;   // same cycle as the regular done
    @(negedge clk); swInjStart = 1'b0;
    waitQuiet();
    check(nLog == 7, "R8 conversion count", nLog, 7);
    for (int i = 0; i < 7; i++)
      check(chLog[i] == exp[i], "R8 preempt order", chLog[i], exp[i]);
    check(longint'(injData[31:0]) == expWord(model(16), 0, 0), "R9 inj rank0",
          longint'(injData[31:0]), expWord(model(16), 0, 0));
    check(longint'(injData[63:32]) == expWord(model(17), 0, 0), "R9 inj rank1",
          longint'(injData[63:32]), expWord(model(17), 0, 0));
    check(nRegAtInj == 2 && regAtInj[0] == expWord(model(2), 0, 0) &&
          regAtInj[1] == expWord(model(2), 0, 0), "R9 regData kept", regAtInj[1],
          expWord(model(2), 0, 0));
    check(lastReg == expWord(model(5), 0, 0), "R8 resume data", lastReg, expWord(model(5), 0, 0));
    check(nEosInj == 1 && nEosReg == 1, "R13 eos each", nEosInj, 1);
  endtask

  task automatic singleConv(input int ch);
    setReg(0, ch);
    pulseSwReg();
    waitQuiet();
  endtask

  task automatic t_res_align();
    doReset();
    cfgRegMode = 2'd0;
    for (int res = 0; res < 4; res++) begin
      for (int l = 0; l < 2; l++) begin
        cfgRes = 2'(res); cfgLeftAlign = l[0];
        singleConv(3);
        check(lastReg == expWord(model(3), res, l[0]), l[0] ? "R11 left align" : "R10 resolution",
              lastReg, expWord(model(3), res, l[0]));
      end
    end
    cfgRes = 2'd0; cfgLeftAlign = 1'b0;
  endtask

  task automatic t_watchdog();
    doReset();
    cfgRegMode = 2'd0; cfgRes = 2'd0;
    cfgWdLow = 12'd600; cfgWdHigh = 12'd700;
    singleConv(3);
    check(nWd == 0, "R12 inside window", nWd, 0);
    singleConv(5);
    check(nWd == 1, "R12 above high", nWd, 1);
    cfgWdLow = 12'd642; cfgWdHigh = 12'd642;
    singleConv(3);
    check(nWd == 1, "R12 equal not flagged", nWd, 1);
    cfgRes = 2'd2; cfgWdLow = 12'd60; cfgWdHigh = 12'd70;
    singleConv(5);
    check(nWd == 1, "R12 reduced value inside", nWd, 1);
    singleConv(7);
    check(nWd == 2, "R12 reduced value outside", nWd, 2);
    cfgWdLow = 12'd100; cfgWdHigh = 12'd200;
    singleConv(7);
    check(nWd == 3, "R12 below low", nWd, 3);
    check(wdOrphan == 0 && nEosReg == 6, "R12 flag with eoc/eos", wdOrphan, 0);
    cfgRes = 2'd0; cfgWdLow = 12'd0; cfgWdHigh = 12'hFFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_trigsel();
    t_scan();
    t_cont();
    t_disc();
    t_preempt();
    t_res_align();
    t_watchdog();
    check(r2Err == 0, "R2 handshake overall", r2Err, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule